// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the bus-cycle master of an 8-bit processor with a 16-bit address space. Core logic asks for a transfer through a small request port: a read or write flag, a memory-or-I/O flag, a 16-bit address and a write byte. The block returns the read byte together with a single-cycle done pulse. On the external side it drives the upper address byte on dedicated output lines. The lower address byte and the data share one bidirectional byte bus in time. A latch-enable pulse marks the address phase, so board logic can hold the low address byte in a latch.

Each bus cycle runs through an address state, a strobe state, any number of wait states while the ready input is low, and a closing state. All bus states advance on an internal tick at half the input clock rate, and that divided clock is also driven out. A hold request lets the cycle in progress finish, then releases every bus line and raises an acknowledge until the hold request is withdrawn. Each group of tri-state lines has its own output-enable signal, and a pad ring or bench resolves the lines from those enables.

Top module: `mbc_bus_ctrl`

## Requirements
- R1: `clk_o` toggles on every `clk_i` edge after reset. One bus state (T-state) lasts exactly two `clk_i` cycles.
- R2: A cycle starts with one T-state in which `ale_o` is high, `ad_oe_o` is high and `ad_o` equals `req_addr_i[7:0]`. `ale_o` is never high while `rd_no` or `wr_no` is low.
- R3: `addr_hi_o` equals `req_addr_i[15:8]` and stays stable from the latch-enable state through the strobe states of the cycle.
- R4: In a read (`req_wr_i`=0), `rd_no` is low for the strobe T-state plus every wait state. `ad_oe_o` is low during that time. `rdata_o` holds the `ad_i` value sampled at the edge where `rd_no` rises.
- R5: In a write (`req_wr_i`=1), `wr_no` is low for the strobe T-state plus every wait state. During that time `ad_oe_o` is high and `ad_o` equals `req_wdata_i`.
- R6: `io_m_o` is 0 for a memory cycle (`req_io_i`=0) and 1 for an I/O cycle (`req_io_i`=1), and it holds that value over the whole cycle.
- R7: If `ready_i` is low at the end of the strobe state, one wait state is inserted per low sample. A cycle with w wait states keeps its strobe low for 2·(w+1) `clk_i` cycles.
- R8: When `hold_i` rises, the current cycle completes with its done pulse. The block then raises `hlda_o` and drops `ad_oe_o`, `addr_hi_oe_o` and `ctrl_oe_o`, and it starts no cycle while `hold_i` stays high, even with `req_i` high. After `hold_i` falls, `hlda_o` clears and pending requests are served.
- R9: While `rst_ni` is low, `rd_no`=`wr_no`=1 and `ale_o`=`ad_oe_o`=`hlda_o`=`done_o`=`clk_o`=0.
- R10: `rd_no` and `wr_no` are never low together.
- R11: `done_o` is a pulse one `clk_i` cycle wide, given once per completed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, held until done_o |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | 16 | Transfer address |
| req_wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-cycle completion pulse |
| addr_hi_o | output | 8 | Upper address byte |
| addr_hi_oe_o | output | 1 | Enable for addr_hi_o |
| ad_o | output | 8 | Shared bus drive value |
| ad_i | input | 8 | Shared bus sensed value |
| ad_oe_o | output | 1 | Enable for ad_o |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | Memory (0) / I/O (1) select |
| ctrl_oe_o | output | 1 | Enable for ale_o, rd_no, wr_no, io_m_o |
| ready_i | input | 1 | Peripheral ready; low inserts wait states |
| hold_i | input | 1 | Bus hold request |
| hlda_o | output | 1 | Hold acknowledge |
| clk_o | output | 1 | Divided clock output |

## Verification
The bus hold and the wait-state stretch can both be active in the same cycle. The bench raises `hold_i` while a read strobe is low and `ready_i` is holding the cycle in wait states. A correct design must finish the full stretched strobe, deliver the read byte and the done pulse, and only then release the buses. A second case raises hold and a request together while the block is idle. Here hold must win: no latch-enable pulse may appear until hold is dropped. In both cases the bench counts strobe and latch-enable widths at every falling edge and compares them with values computed from the requested wait count.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_HOLD
  } bus_state_e;
endpackage

// File: rtl/mbc_clk_div.sv
module mbc_clk_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic clk_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
  assign clk_o  = (cnt_q >= HALF);
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          req_wr_i,
  input  logic          req_io_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          ready_i,
  input  logic          hold_i,
  input  logic [DW-1:0] ad_i,
  output bus_state_e    state_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          cur_wr_o,
  output logic          cur_io_o,
  output logic [DW-1:0] cur_wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  bus_state_e    st_q;
  logic [AW-1:0] addr_q;
  logic          wr_q, io_q, done_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            // hold outranks a pending request
            if (hold_i) st_q <= ST_HOLD;
            else if (req_i) begin
              addr_q  <= req_addr_i;
              wr_q    <= req_wr_i;
              io_q    <= req_io_i;
              wdata_q <= req_wdata_i;
              st_q    <= ST_T1;
            end
          end
          ST_T1: st_q <= ST_T2;
          ST_T2, ST_TW: begin
            if (ready_i) begin
              if (!wr_q) rdata_q <= ad_i;
              st_q <= ST_T3;
            end else begin
              st_q <= ST_TW;
            end
          end
          ST_T3: begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
          ST_HOLD: if (!hold_i) st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o     = st_q;
  assign cur_addr_o  = addr_q;
  assign cur_wr_o    = wr_q;
  assign cur_io_o    = io_q;
  assign cur_wdata_o = wdata_q;
  assign rdata_o     = rdata_q;
  assign done_o      = done_q;
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  bus_state_e       state_i,
  input  logic [AW-1:0]    cur_addr_i,
  input  logic             cur_wr_i,
  input  logic             cur_io_i,
  input  logic [DW-1:0]    cur_wdata_i,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic             addr_hi_oe_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             io_m_o,
  output logic             ctrl_oe_o,
  output logic             hlda_o
);
  logic in_t1, in_strobe, in_data, in_hold;

  always_comb begin
    in_t1     = (state_i == ST_T1);
    in_strobe = (state_i == ST_T2) || (state_i == ST_TW);
    in_data   = in_strobe || (state_i == ST_T3);
    in_hold   = (state_i == ST_HOLD);

    addr_hi_o    = cur_addr_i[AW-1:DW];
    addr_hi_oe_o = !in_hold;
    ctrl_oe_o    = !in_hold;
    hlda_o       = in_hold;
    ale_o        = in_t1;
    // shared bus driven only for address and write data
    ad_oe_o      = in_t1 || (cur_wr_i && in_data);
    ad_o         = in_t1 ? cur_addr_i[DW-1:0] : cur_wdata_i;
    rd_no        = !(in_strobe && !cur_wr_i);
    wr_no        = !(in_strobe && cur_wr_i);
    io_m_o       = cur_io_i;
  end
endmodule

// File: rtl/mbc_bus_ctrl.sv
module mbc_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 8,
  parameter int unsigned DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_wr_i,
  input  logic             req_io_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic             addr_hi_oe_o,
  output logic [DW-1:0]    ad_o,
  input  logic [DW-1:0]    ad_i,
  output logic             ad_oe_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             io_m_o,
  output logic             ctrl_oe_o,
  input  logic             ready_i,
  input  logic             hold_i,
  output logic             hlda_o,
  output logic             clk_o
);
  logic          tick;
  bus_state_e    state;
  logic [AW-1:0] cur_addr;
  logic          cur_wr, cur_io;
  logic [DW-1:0] cur_wdata;

  mbc_clk_div #(.DIV(DIV)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick),
    .clk_o  (clk_o)
  );

  mbc_seq #(.AW(AW), .DW(DW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .req_i       (req_i),
    .req_wr_i    (req_wr_i),
    .req_io_i    (req_io_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .ready_i     (ready_i),
    .hold_i      (hold_i),
    .ad_i        (ad_i),
    .state_o     (state),
    .cur_addr_o  (cur_addr),
    .cur_wr_o    (cur_wr),
    .cur_io_o    (cur_io),
    .cur_wdata_o (cur_wdata),
    .rdata_o     (rdata_o),
    .done_o      (done_o)
  );

  mbc_pins #(.AW(AW), .DW(DW)) i_pins (
    .state_i      (state),
    .cur_addr_i   (cur_addr),
    .cur_wr_i     (cur_wr),
    .cur_io_i     (cur_io),
    .cur_wdata_i  (cur_wdata),
    .addr_hi_o    (addr_hi_o),
    .addr_hi_oe_o (addr_hi_oe_o),
    .ad_o         (ad_o),
    .ad_oe_o      (ad_oe_o),
    .ale_o        (ale_o),
    .rd_no        (rd_no),
    .wr_no        (wr_no),
    .io_m_o       (io_m_o),
    .ctrl_oe_o    (ctrl_oe_o),
    .hlda_o       (hlda_o)
  );
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic [AW-DW-1:0] addr_hi_o,
  input logic             addr_hi_oe_o,
  input logic             ad_oe_o,
  input logic             ale_o,
  input logic             rd_no,
  input logic             wr_no,
  input logic             io_m_o,
  input logic             ctrl_oe_o,
  input logic             hlda_o,
  input logic             clk_o
);
  p_clk_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (clk_o != $past(clk_o)));

  p_ale_no_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no));

  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no || !wr_no) && $past(!rd_no || !wr_no)) |-> $stable(addr_hi_o));

  p_io_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no || !wr_no) && $past(!rd_no || !wr_no)) |-> $stable(io_m_o));

  p_read_no_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);

  p_hold_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !addr_hi_oe_o && !ctrl_oe_o));

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind mbc_bus_ctrl mbc_checker #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_mbc_bus_ctrl.sv
module test_mbc_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0, req_io = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rdata, ad_o, ad_i, addr_hi;
  logic        done, addr_hi_oe, ad_oe, ale, rd_n, wr_n, io_m, ctrl_oe, hlda, clk_out;
  logic        ready = 1'b1, hold = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // monitor state
  bit          mon_en = 1'b0;
  int          ale_cnt, rd_cnt, wr_cnt, n_low, exp_waits;
  int          hi_err, io_err, rdrv_err, wd_err, ale_seen;
  logic [7:0]  cap_lo, exp_hi, exp_wd, drv;
  logic        exp_io;
  bit          hold_on_strobe = 1'b0;

  always #5 clk = ~clk;

  assign ad_i = ad_oe ? ad_o : drv;

  mbc_bus_ctrl i_mbc_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(req_wr), .req_io_i(req_io),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rdata_o(rdata), .done_o(done),
    .addr_hi_o(addr_hi), .addr_hi_oe_o(addr_hi_oe), .ad_o(ad_o), .ad_i(ad_i),
    .ad_oe_o(ad_oe), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n), .io_m_o(io_m),
    .ctrl_oe_o(ctrl_oe), .ready_i(ready), .hold_i(hold), .hlda_o(hlda), .clk_o(clk_out)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, expv, $time);
    end
  endtask

  // bus monitor and ready generator
  initial forever begin
    @(negedge clk);
    if (mon_en) begin
      if (ale) begin
        ale_cnt++;
        ale_seen++;
        cap_lo = ad_o;
        if (!ad_oe) rdrv_err++;
      end
      if (ale || !rd_n || !wr_n) begin
        if (addr_hi !== exp_hi) hi_err++;
        if (io_m !== exp_io) io_err++;
      end
      if (!rd_n) begin
        rd_cnt++;
        if (ad_oe) rdrv_err++;
      end
      if (!wr_n) begin
        wr_cnt++;
        if (!ad_oe || ad_o !== exp_wd) wd_err++;
      end
    end
    if (!rd_n || !wr_n) begin
      n_low++;
      ready = (n_low >= 2 * exp_waits + 1);
      if (hold_on_strobe) hold = 1'b1;
    end else begin
      n_low = 0;
      ready = 1'b1;
    end
  end

  task automatic clear_mon();
    ale_cnt = 0; rd_cnt = 0; wr_cnt = 0;
    hi_err = 0; io_err = 0; rdrv_err = 0; wd_err = 0;
  endtask

  task automatic start(input logic [15:0] a, input bit w, input bit io, input int waits,
                       input logic [7:0] wd);
    @(negedge clk);
    clear_mon();
    exp_hi = a[15:8]; exp_io = io; exp_wd = wd; exp_waits = waits;
    drv = mem_byte(a);
    req_addr = a; req_wr = w; req_io = io; req_wdata = wd; req = 1'b1;
    mon_en = 1'b1;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    req = 1'b0;
  endtask

  task automatic judge(input logic [15:0] a, input bit w, input int waits, input bit got);
    chk(got, "R11 done arrives", got, 1);
    chk(ale_cnt == 2, "R1/R2 ale width", ale_cnt, 2);
    chk(cap_lo == a[7:0], "R2 low address on ad", cap_lo, a[7:0]);
    chk(hi_err == 0, "R3 addr_hi", hi_err, 0);
    chk(io_err == 0, "R6 io_m", io_err, 0);
    if (w) begin
      chk(wr_cnt == 2 * (waits + 1), "R5/R7 wr width", wr_cnt, 2 * (waits + 1));
      chk(rd_cnt == 0, "R10 no read strobe on write", rd_cnt, 0);
      chk(wd_err == 0, "R5 write data", wd_err, 0);
    end else begin
      chk(rd_cnt == 2 * (waits + 1), "R4/R7 rd width", rd_cnt, 2 * (waits + 1));
      chk(wr_cnt == 0, "R10 no write strobe on read", wr_cnt, 0);
      chk(rdrv_err == 0, "R4 no drive in read", rdrv_err, 0);
      chk(rdata == mem_byte(a), "R4 read data", rdata, mem_byte(a));
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
    mon_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [15:0] a;
    logic [7:0]  prev;
    int          toggles;
    drv = 8'h00; exp_waits = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rd_n && wr_n, "R9 strobes high", {rd_n, wr_n}, 3);
    chk(!ale && !ad_oe, "R9 ale/ad_oe low", {ale, ad_oe}, 0);
    chk(!hlda && !done && !clk_out, "R9 hlda/done/clk_o low", {hlda, done, clk_out}, 0);
    rst_n = 1'b1;

    // R1 divided clock
    toggles = 0;
    @(negedge clk); prev = {7'b0, clk_out};
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (clk_out != prev[0]) toggles++;
      prev = {7'b0, clk_out};
    end
    chk(toggles == 16, "R1 clk_o toggles", toggles, 16);

    // sweep: waits x kind x address pattern
    for (int w = 0; w < 4; w++)
      for (int kind = 0; kind < 4; kind++)
        for (int ix = 0; ix < 4; ix++) begin
          a = 16'(ix * 16'h4B1D + kind * 16'h0F0F + w * 16'h1111) ^ 16'hC3A5;
          start(a, kind[0], kind[1], w, 8'(a[7:0] + 8'(ix * 37 + 1)));
          wait_done(got);
          judge(a, kind[0], w, got);
        end

    // R8 hold during a stretched read
    a = 16'h9A3C;
    hold_on_strobe = 1'b1;
    start(a, 1'b0, 1'b0, 2, 8'h00);
    wait_done(got);
    hold_on_strobe = 1'b0;
    judge(a, 1'b0, 2, got);
    repeat (6) @(negedge clk);
    chk(hlda, "R8 hlda after cycle", hlda, 1);
    chk(!ad_oe && !addr_hi_oe && !ctrl_oe, "R8 buses released",
        {ad_oe, addr_hi_oe, ctrl_oe}, 0);

    // R8 request while held: no cycle starts
    ale_seen = 0;
    a = 16'h1E77;
    start(a, 1'b1, 1'b1, 1, 8'h5C);
    repeat (20) @(negedge clk);
    chk(ale_seen == 0, "R8 no cycle under hold", ale_seen, 0);
    chk(hlda, "R8 hlda held", hlda, 1);
    hold = 1'b0;
    wait_done(got);
    judge(a, 1'b1, 1, got);
    chk(!hlda && ctrl_oe, "R8 hold released", {hlda, ctrl_oe}, 1);

    // R8 hold and request raised together while idle
    repeat (4) @(negedge clk);
    ale_seen = 0;
    hold = 1'b1;
    a = 16'h0480;
    start(a, 1'b0, 1'b1, 0, 8'h00);
    repeat (12) @(negedge clk);
    chk(ale_seen == 0 && hlda, "R8 hold wins over request", ale_seen, 0);
    hold = 1'b0;
    wait_done(got);
    judge(a, 1'b0, 0, got);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule